// File: doc/BRIEF.md
# Gate Pre-Driver Power-Up Sequencer

This block sits between a three-phase PWM generator and a MOSFET gate pre-driver. After a system reset it runs a single timed power-up handshake. First it releases the pre-driver's reset line. Then it raises the two enable lines. It then fires one pulse on all three low-side gate commands, which arms the high-side stages. Finally it drives all three active-low high-side commands into their "on" level for one pulse, which latches them. Only when that handshake is over does it raise a done flag. That flag is meant to switch on PWM generation and the period-start trigger.

Until the done flag rises, every gate line is held at its non-conducting level: low-side commands low, active-low high-side commands high. The only exceptions are the two pulses. The PWM inputs are ignored during this time. Once the flag is set, the six gate commands follow the PWM generator through one register stage.

All intervals are whole clock cycles. The step wait and the dead time are given directly as cycle counts. The low-side pulse length and the extra high-side guard time are given in nanoseconds and converted to cycles from the clock frequency, always rounding up. The reset is synchronous and active high.

Top module: `gate_predrv_startup`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become: `drv_rstb`=0, `drv_en_a`=`drv_en_b`=0, `ls_cmd`=000, `hs_cmd_n`=111, `seq_done`=0. This holds even if the reset arrives in the middle of the sequence, and the sequence then starts over.
- R2: `drv_rstb` rises WAIT_CYC cycles after reset release, while both enable lines are still 0, and stays 1 afterwards.
- R3: Both enable lines rise together WAIT_CYC cycles after `drv_rstb`, and stay 1 afterwards.
- R4: WAIT_CYC cycles after the enables rise, all three bits of `ls_cmd` go to 1 together. They stay there for ceil(LS_PULSE_NS·CLK_HZ/1e9) cycles.
- R5: WAIT_CYC cycles after the low-side pulse ends, all three bits of `hs_cmd_n` go to 0 together. They stay there for DEAD_CYC + ceil(HS_GUARD_NS·CLK_HZ/1e9) cycles.
- R6: Before `seq_done` is set, any gate line not inside its own pulse holds its safe level (`ls_cmd` bit 0, `hs_cmd_n` bit 1). No leg ever has both its low-side and high-side command active at once.
- R7: Before `seq_done` is set, `pwm_ls` and `pwm_hs_n` have no effect on any output.
- R8: `seq_done` rises WAIT_CYC cycles after the high-side pulse ends. It stays 1 until the next reset, so the sequence runs only once.
- R9: From the cycle in which `seq_done` rises, `ls_cmd` and `hs_cmd_n` equal the `pwm_ls` and `pwm_hs_n` values sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| pwm_ls | input | NPH | Low-side commands from the PWM generator (1 = on) |
| pwm_hs_n | input | NPH | High-side commands from the PWM generator (0 = on) |
| drv_rstb | output | 1 | Pre-driver reset line (0 = held in reset) |
| drv_en_a | output | 1 | Pre-driver enable line one |
| drv_en_b | output | 1 | Pre-driver enable line two |
| ls_cmd | output | NPH | Low-side gate commands to the pre-driver |
| hs_cmd_n | output | NPH | Active-low high-side gate commands to the pre-driver |
| seq_done | output | 1 | Sequence finished; enables PWM and the period trigger |

## Verification
Random values are driven on `pwm_ls` and `pwm_hs_n` in every cycle of the sequence. Any leak of PWM values onto the gate lines before done is therefore caught as a mismatch against the cycle-exact expected schedule. The same random values after done show whether the pass-through has exactly one cycle of latency, rather than zero or two.

The nanosecond lengths are chosen so that neither converts to a whole number of cycles. This separates rounding up from truncation. Two directed patterns are also used. A reset issued inside the low-side pulse shows whether the sequencer clears and restarts cleanly. Alternating all-on and all-off PWM words after done test every bit of the pass-through path.

// File: rtl/gds_pkg.sv
package gds_pkg;

  typedef enum logic [2:0] {
    PH_HOLD = 3'd0,
    PH_RST  = 3'd1,
    PH_EN   = 3'd2,
    PH_LS   = 3'd3,
    PH_GAP1 = 3'd4,
    PH_HS   = 3'd5,
    PH_GAP2 = 3'd6,
    PH_DONE = 3'd7
  } gds_phase_e;

  // nanoseconds to clock cycles, rounded up
  function automatic longint ns_to_cyc(longint ns, longint hz);
    return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/gds_timer.sv
module gds_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/gds_fsm.sv
module gds_fsm
  import gds_pkg::*;
#(
  parameter int WAIT_CYC = 5,
  parameter int LS_CYC   = 100,
  parameter int HS_CYC   = 30,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  output gds_phase_e       phase_q,
  output gds_phase_e       phase_d,
  output logic             restart
);

  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] LS_LAST   = CNT_W'(LS_CYC - 1);
  localparam logic [CNT_W-1:0] HS_LAST   = CNT_W'(HS_CYC - 1);

  logic [CNT_W-1:0] last_val;
  logic             at_last;

  always_comb begin
    unique case (phase_q)
      PH_LS:   last_val = LS_LAST;
      PH_HS:   last_val = HS_LAST;
      default: last_val = WAIT_LAST;
    endcase
    at_last = (cnt == last_val) && (phase_q != PH_DONE);
    phase_d = at_last ? gds_phase_e'(phase_q + 3'd1) : phase_q;
    restart = at_last || (phase_q == PH_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_HOLD;
    else     phase_q <= phase_d;
  end

  // R2 phases only ever move one step forward
  assert_step_forward_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q)) |-> (3'(phase_q) == 3'($past(phase_q)) + 3'd1));

  // R4 a timed phase never runs past its own length
  assert_ls_len_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LS) |-> (cnt <= LS_LAST));

  // R5 high-side pulse bounded
  assert_hs_len_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HS) |-> (cnt <= HS_LAST));

endmodule

// File: rtl/gds_outreg.sv
module gds_outreg
  import gds_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  gds_phase_e     phase_d,
  input  logic [NPH-1:0] pwm_ls,
  input  logic [NPH-1:0] pwm_hs_n,
  output logic           drv_rstb,
  output logic           drv_en_a,
  output logic           drv_en_b,
  output logic [NPH-1:0] ls_cmd,
  output logic [NPH-1:0] hs_cmd_n,
  output logic           seq_done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_rstb <= 1'b0;
      drv_en_a <= 1'b0;
      drv_en_b <= 1'b0;
      ls_cmd   <= '0;
      hs_cmd_n <= '1;
      seq_done <= 1'b0;
    end else begin
      drv_rstb <= (phase_d != PH_HOLD);
      drv_en_a <= (phase_d >= PH_EN);
      drv_en_b <= (phase_d >= PH_EN);
      seq_done <= (phase_d == PH_DONE);
      unique case (phase_d)
        PH_LS: begin
          ls_cmd   <= '1;
          hs_cmd_n <= '1;
        end
        PH_HS: begin
          ls_cmd   <= '0;
          hs_cmd_n <= '0;
        end
        PH_DONE: begin
          ls_cmd   <= pwm_ls;
          hs_cmd_n <= pwm_hs_n;
        end
        default: begin
          ls_cmd   <= '0;
          hs_cmd_n <= '1;
        end
      endcase
    end
  end

  // R3 enables only with the pre-driver out of reset
  assert_en_after_rstb_R3: assert property (@(posedge clk) disable iff (rst)
    (drv_en_a || drv_en_b) |-> drv_rstb);

  // R4 low-side pulse is all-or-nothing and needs the enables
  assert_ls_group_R4: assert property (@(posedge clk) disable iff (rst)
    (!seq_done && (ls_cmd != '0)) |-> ((ls_cmd == '1) && drv_en_a && drv_en_b));

  // R5 high-side pulse is all-or-nothing
  assert_hs_group_R5: assert property (@(posedge clk) disable iff (rst)
    !seq_done |-> ((hs_cmd_n == '1) || (hs_cmd_n == '0)));

  // R6 no leg conducts on both sides during the sequence
  assert_no_shoot_R6: assert property (@(posedge clk) disable iff (rst)
    !seq_done |-> ((ls_cmd & ~hs_cmd_n) == '0));

  // R8 done never drops without reset
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> seq_done);

endmodule

// File: rtl/gate_predrv_startup.sv
module gate_predrv_startup
  import gds_pkg::*;
#(
  parameter int     NPH         = 3,
  parameter longint CLK_HZ      = 100_000_000,
  parameter int     WAIT_CYC    = 50,
  parameter int     LS_PULSE_NS = 1000,
  parameter int     HS_GUARD_NS = 100,
  parameter int     DEAD_CYC    = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] pwm_ls,
  input  logic [NPH-1:0] pwm_hs_n,
  output logic           drv_rstb,
  output logic           drv_en_a,
  output logic           drv_en_b,
  output logic [NPH-1:0] ls_cmd,
  output logic [NPH-1:0] hs_cmd_n,
  output logic           seq_done
);

  localparam int LS_CYC  = int'(ns_to_cyc(longint'(LS_PULSE_NS), CLK_HZ));
  localparam int HS_CYC  = DEAD_CYC + int'(ns_to_cyc(longint'(HS_GUARD_NS), CLK_HZ));
  localparam int MAX_A   = (LS_CYC > HS_CYC) ? LS_CYC : HS_CYC;
  localparam int MAX_LEN = (MAX_A > WAIT_CYC) ? MAX_A : WAIT_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic             restart;
  gds_phase_e       phase_q;
  gds_phase_e       phase_d;

  gds_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .cnt     (cnt)
  );

  gds_fsm #(
    .WAIT_CYC (WAIT_CYC),
    .LS_CYC   (LS_CYC),
    .HS_CYC   (HS_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .restart (restart)
  );

  gds_outreg #(.NPH(NPH)) u_out (
    .clk      (clk),
    .rst      (rst),
    .phase_d  (phase_d),
    .pwm_ls   (pwm_ls),
    .pwm_hs_n (pwm_hs_n),
    .drv_rstb (drv_rstb),
    .drv_en_a (drv_en_a),
    .drv_en_b (drv_en_b),
    .ls_cmd   (ls_cmd),
    .hs_cmd_n (hs_cmd_n),
    .seq_done (seq_done)
  );

  initial begin
    assert_params_R4: assert (WAIT_CYC >= 1 && LS_CYC >= 1 && HS_CYC >= 1);
  end

endmodule

// File: tb/sim_gate_predrv_startup.sv
module sim_gate_predrv_startup;

  localparam int     NPH  = 3;
  localparam longint HZ   = 100_000_000;
  localparam int     W    = 5;
  localparam int     LSNS = 1005;
  localparam int     GNS  = 101;
  localparam int     DEAD = 7;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NPH-1:0] pwm_ls = '0;
  logic [NPH-1:0] pwm_hs_n = '1;
  logic           drv_rstb, drv_en_a, drv_en_b, seq_done;
  logic [NPH-1:0] ls_cmd, hs_cmd_n;

  int checks = 0;
  int errors = 0;
  int lcyc, hcyc;
  logic [NPH-1:0] prev_ls, prev_hs_n;

  always #5 clk = ~clk;

  gate_predrv_startup #(
    .NPH(NPH), .CLK_HZ(HZ), .WAIT_CYC(W),
    .LS_PULSE_NS(LSNS), .HS_GUARD_NS(GNS), .DEAD_CYC(DEAD)
  ) u0 (
    .clk(clk), .rst(rst), .pwm_ls(pwm_ls), .pwm_hs_n(pwm_hs_n),
    .drv_rstb(drv_rstb), .drv_en_a(drv_en_a), .drv_en_b(drv_en_b),
    .ls_cmd(ls_cmd), .hs_cmd_n(hs_cmd_n), .seq_done(seq_done)
  );

  function automatic int up_cyc(int ns);
    longint num = longint'(ns) * HZ;
    int c = int'(num / 64'd1_000_000_000);
    if (longint'(c) * 64'd1_000_000_000 < num) c = c + 1;
    return c;
  endfunction

  // expected {rstb, en_a, en_b, ls, hs_n, done} n cycles after release
  function automatic logic [9:0] exp_out(int n, logic [NPH-1:0] pl, logic [NPH-1:0] ph);
    if (n < W)                          return {1'b0, 2'b00, 3'b000, 3'b111, 1'b0};
    if (n < 2*W)                        return {1'b1, 2'b00, 3'b000, 3'b111, 1'b0};
    if (n < 3*W)                        return {1'b1, 2'b11, 3'b000, 3'b111, 1'b0};
    if (n < 3*W + lcyc)                 return {1'b1, 2'b11, 3'b111, 3'b111, 1'b0};
    if (n < 4*W + lcyc)                 return {1'b1, 2'b11, 3'b000, 3'b111, 1'b0};
    if (n < 4*W + lcyc + hcyc)          return {1'b1, 2'b11, 3'b000, 3'b000, 1'b0};
    if (n < 5*W + lcyc + hcyc)          return {1'b1, 2'b11, 3'b000, 3'b111, 1'b0};
    return {1'b1, 2'b11, pl, ph, 1'b1};
  endfunction

  function automatic string req_of(int n);
    if (n < W)                 return "R2";
    if (n < 2*W)               return "R3";
    if (n < 3*W)               return "R4";
    if (n < 3*W + lcyc)        return "R4";
    if (n < 4*W + lcyc)        return "R5";
    if (n < 4*W + lcyc + hcyc) return "R5";
    if (n < 5*W + lcyc + hcyc) return "R8";
    return "R9";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [9:0] act_out();
    return {drv_rstb, drv_en_a, drv_en_b, ls_cmd, hs_cmd_n, seq_done};
  endfunction

  task automatic check_reset_state();
    logic [9:0] a = act_out();
    chk(a == {1'b0, 2'b00, 3'b000, 3'b111, 1'b0}, "R1", "reset state",
        32'(a), 32'({1'b0, 2'b00, 3'b000, 3'b111, 1'b0}));
  endtask

  // called at a negedge just after rst drops; runs ncyc cycles
  task automatic run_seq(input int ncyc, input bit directed);
    int ls_w = 0;
    int hs_w = 0;
    for (int n = 0; n < ncyc; n++) begin
      logic [9:0] a = act_out();
      logic [9:0] e = exp_out(n, prev_ls, prev_hs_n);
      chk(a == e, (n < 5*W + lcyc + hcyc) ? {req_of(n), "/R6/R7"} : req_of(n),
          "per-cycle outputs", 32'(a), 32'(e));
      if (ls_cmd == '1 && !seq_done) ls_w++;
      if (hs_cmd_n == '0 && !seq_done) hs_w++;
      if (directed && n >= 5*W + lcyc + hcyc) begin
        pwm_ls   = n[0] ? '1 : '0;
        pwm_hs_n = n[0] ? '0 : '1;
      end else begin
        pwm_ls   = NPH'($urandom);
        pwm_hs_n = NPH'($urandom);
      end
      prev_ls   = pwm_ls;
      prev_hs_n = pwm_hs_n;
      @(negedge clk);
    end
    if (ncyc > 5*W + lcyc + hcyc) begin
      chk(ls_w == lcyc, "R4", "low-side pulse width", 32'(ls_w), 32'(lcyc));
      chk(hs_w == hcyc, "R5", "high-side pulse width", 32'(hs_w), 32'(hcyc));
    end
  endtask

  initial begin
    bit done_flag;
    done_flag = 0;
    fork
      begin
        void'($urandom(32'd4711));
        lcyc = up_cyc(LSNS);
        hcyc = DEAD + up_cyc(GNS);
        prev_ls = '0;
        prev_hs_n = '1;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        // first pass: interrupted inside the low-side pulse
        run_seq(3*W + 20, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state();
        @(negedge clk);
        rst = 1'b0;
        // second pass: full run with random PWM, then directed patterns
        run_seq(5*W + lcyc + hcyc + 60, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        run_seq(5*W + lcyc + hcyc + 20, 1'b1);
        chk(seq_done == 1'b1, "R8", "done held at end", 32'(seq_done), 32'd1);
        done_flag = 1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!done_flag) begin
          errors++;
          $display("FAIL watchdog expired actual=running expected=finished");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule